// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a first-level cache and keeps a short queue of lines fetched ahead of demand. Each cache miss is offered to the buffer, and the buffer compares it against the oldest queued entry only. If the oldest entry holds the missed line, the buffer returns that line to the cache and pops it. The freed slot is then used to fetch the next sequential line. If the oldest entry holds a different line, the buffer discards its whole contents. It answers "no hit" so the cache fetches the line itself, and it starts a new stream at the line that follows the miss.

All addresses are line addresses: one unit is one cache line. Memory fetches leave the block through a valid/ready request port. Every request carries a tag made of a stream number and a slot number, and fill data comes back through a response port that echoes that tag. Fills may return in any order. When the oldest entry matches a miss but its data is still outstanding, the miss port stalls until that fill arrives. After a flush, any fill still in flight is recognised by its old stream number and dropped.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: After reset, `miss_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0. No memory request is made before the first miss has been accepted.
- R2: A miss that does not match the oldest entry is answered one cycle after acceptance with `resp_valid`=1, `resp_hit`=0 and `resp_addr` equal to the miss address. The buffer then requests the lines miss+1, miss+2 and so on in ascending order, at most one request per cycle.
- R3: At most DEPTH lines (default 8) are held or outstanding. With no pops, exactly DEPTH requests follow a restart, and `mem_req_valid` then stays 0.
- R4: A miss that matches the oldest entry, with data present, is answered one cycle after acceptance with `resp_hit`=1, `resp_addr` equal to the miss address and `resp_data` equal to that line's fill data.
- R5: Consuming the oldest entry frees a slot, and the next request is for the line after the last one requested.
- R6: Only the oldest entry is compared. A miss that matches a deeper entry is answered with `resp_hit`=0, and the new stream's requests begin at that miss address plus one.
- R7: A miss that matches an oldest entry whose fill is still outstanding drives `miss_ready` to 0 with `resp_valid` held at 0. The hit response comes in the cycle after that fill arrives and carries the fill's data.
- R8: A fill whose tag holds a stream number from before the most recent flush writes nothing. A later miss to a still-pending entry in the same slot keeps stalling, and it does not return the stale data.
- R9: The next request address wraps to 0 after the all-ones line address.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request address and tag stay unchanged unless a flush occurs.
- R11: `mem_req_tag` is {stream number, slot index}, with the slot index in the low $clog2(DEPTH) bits. A restart makes the first request use slot 0. Each later request uses the next slot, wrapping after DEPTH-1. A fill is matched to its entry through this same field split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Buffer can accept a miss this cycle |
| miss_addr | input | ADDR_W | Line address of the miss |
| resp_valid | output | 1 | One-cycle answer to an accepted miss |
| resp_hit | output | 1 | 1 = line supplied by the buffer |
| resp_addr | output | ADDR_W | Line address being answered |
| resp_data | output | DATA_W | Line data on a hit, 0 otherwise |
| mem_req_valid | output | 1 | Prefetch request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Line address to fetch |
| mem_req_tag | output | SID_W+$clog2(DEPTH) | {stream number, slot index} |
| mem_rsp_valid | input | 1 | Fill data returning |
| mem_rsp_tag | input | SID_W+$clog2(DEPTH) | Tag echoed from the request |
| mem_rsp_data | input | DATA_W | Fill data |

## Verification
If the head pointer or the slot tags are corrupted, a sequential miss is answered with `resp_hit`=0 one cycle after it is accepted. That error also shows up when the next request address jumps. If the pending bits are wrong, the symptom depends on the direction of the error. A bit that is wrongly clear returns stale or zero data in the response cycle. A bit that is wrongly set holds `miss_ready` low indefinitely. If a stale fill is not filtered, the next miss that lands on a pending entry returns immediately instead of stalling. A miscounted occupancy is seen at the request port: the buffer makes a ninth request with no pop, or it stops short.

// File: rtl/spb_pkg.sv
// Package: shared types for the sequential stream prefetch buffer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package spb_pkg;

    // Miss handling state of the top-level controller.
    typedef enum logic {
        ST_IDLE = 1'b0,   // ready for a new miss
        ST_WAIT = 1'b1    // head matched but its fill is outstanding
    } spb_state_t;

endpackage

// File: rtl/spb_slot_array.sv
// Module: spb_slot_array
// Holds DEPTH line slots. Each slot has a line tag, a valid bit, a pending bit
// and line data. Slots are allocated pending, completed by fills and released by
// pops, and a single clear empties them all.
// Assumes: only a valid, pending slot is allocated never; the caller never
// allocates and pops the same slot in one cycle.
module spb_slot_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              pop_en,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  pend_q;
    logic [ADDR_W-1:0] tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic hit_alloc, hit_pop, hit_fill;
        assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
        assign hit_pop   = pop_en   && (rd_idx    == IDX_W'(i));
        assign hit_fill  = fill_en  && (fill_idx  == IDX_W'(i)) && valid_q[i] && pend_q[i];

        // Slot status: allocate, complete, release or clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                valid_q[i] <= 1'b0;
                pend_q[i]  <= 1'b0;
            end else begin
                if (hit_alloc) begin
                    valid_q[i] <= 1'b1;
                    pend_q[i]  <= 1'b1;
                end else if (hit_pop) begin
                    valid_q[i] <= 1'b0;
                end
                if (hit_fill) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end

        // Slot payload: line tag on allocation, line data on a live fill.
        always_ff @(posedge clk) begin
            if (hit_alloc) begin
                tag_q[i] <= alloc_addr;
            end
            if (hit_fill) begin
                data_q[i] <= fill_data;
            end
        end

        // A completed slot keeps its data until it is released (stale fills cannot touch it).
        assert_data_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[i] && !pend_q[i]) |=> (!valid_q[i] || $stable(data_q[i])));
    end

    // Read port for the head slot.
    assign rd_valid = valid_q[rd_idx];
    assign rd_pend  = pend_q[rd_idx];
    assign rd_addr  = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/spb_fetch_ctrl.sv
// Module: spb_fetch_ctrl
// Owns the queue pointers, the occupancy count, the next line address and the
// stream number. It issues one sequential fetch per cycle while a slot is free.
// Assumes: DEPTH >= 2; restart and pop are never asserted in the same cycle.
module spb_fetch_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    parameter int SID_W  = 3,
    parameter int IDX_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic [ADDR_W-1:0]      restart_addr,
    input  logic                   pop,
    input  logic                   mem_req_ready,
    output logic                   mem_req_valid,
    output logic [ADDR_W-1:0]      mem_req_addr,
    output logic [SID_W+IDX_W-1:0] mem_req_tag,
    output logic                   alloc_en,
    output logic [IDX_W-1:0]       alloc_idx,
    output logic [ADDR_W-1:0]      alloc_addr,
    output logic [IDX_W-1:0]       head_idx,
    output logic [SID_W-1:0]       cur_sid
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              active_q;
    logic [IDX_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] next_q;
    logic [SID_W-1:0]  sid_q;

    // Advance a slot pointer with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    // Request port and allocation handshake.
    always_comb begin
        mem_req_valid = active_q && (count_q < CNT_W'(DEPTH));
        mem_req_addr  = next_q;
        mem_req_tag   = {sid_q, tail_q};
        alloc_en      = mem_req_valid && mem_req_ready;
        alloc_idx     = tail_q;
        alloc_addr    = next_q;
        head_idx      = head_q;
        cur_sid       = sid_q;
    end

    // Pointer, count, address and stream bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            head_q   <= '0;
            tail_q   <= '0;
            count_q  <= '0;
            next_q   <= '0;
            sid_q    <= '0;
        end else if (restart) begin
            active_q <= 1'b1;
            head_q   <= '0;
            tail_q   <= '0;
            count_q  <= '0;
            next_q   <= restart_addr + ADDR_W'(1);
            sid_q    <= sid_q + SID_W'(1);
        end else begin
            if (alloc_en) begin
                tail_q <= step(tail_q);
                next_q <= next_q + ADDR_W'(1);
            end
            if (pop) begin
                head_q <= step(head_q);
            end
            unique case ({alloc_en, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Occupancy never exceeds the queue depth.
    assert_depth_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // An accepted request is followed by the next line address (wrapping).
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !restart) |=> (mem_req_addr == ADDR_W'($past(mem_req_addr) + ADDR_W'(1))));

    // A stalled request holds address and tag.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !restart)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag)));

endmodule

// File: rtl/stream_prefetch_buffer.sv
// Module: stream_prefetch_buffer (top)
// A sequential stream prefetch buffer. A miss is compared against the head
// entry only: a ready head is returned and popped; a pending head stalls the
// miss port until its fill; any mismatch flushes and restarts at miss+1.
// Assumes: DEPTH >= 2; fewer than 2**SID_W flushes occur while a fill is in flight.
module stream_prefetch_buffer
    import spb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int SID_W  = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = SID_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    spb_state_t        state_q;
    logic              accept, head_match, restart, pop, go_wait;
    logic              head_ready_now, fill_live;
    logic [DATA_W-1:0] head_data_now;
    logic [IDX_W-1:0]  fill_idx, head_idx, alloc_idx;
    logic [SID_W-1:0]  fill_sid, cur_sid;
    logic [ADDR_W-1:0] alloc_addr, rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              alloc_en, rd_valid, rd_pend;

    spb_fetch_ctrl #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SID_W(SID_W), .IDX_W(IDX_W)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n),
        .restart(restart), .restart_addr(miss_addr), .pop(pop),
        .mem_req_ready(mem_req_ready), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr),
        .head_idx(head_idx), .cur_sid(cur_sid)
    );

    spb_slot_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) i_slots (
        .clk(clk), .rst_n(rst_n), .clr_all(restart),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr),
        .pop_en(pop),
        .fill_en(fill_live), .fill_idx(fill_idx), .fill_data(mem_rsp_data),
        .rd_idx(head_idx), .rd_valid(rd_valid), .rd_pend(rd_pend),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Fill filtering, head comparison and the serve/stall/flush decision.
    always_comb begin
        fill_idx       = mem_rsp_tag[IDX_W-1:0];
        fill_sid       = mem_rsp_tag[TAG_W-1:IDX_W];
        fill_live      = mem_rsp_valid && (fill_sid == cur_sid);
        miss_ready     = (state_q == ST_IDLE);
        accept         = miss_valid && miss_ready;
        head_match     = rd_valid && (rd_addr == miss_addr);
        head_ready_now = !rd_pend || (fill_live && (fill_idx == head_idx));
        head_data_now  = rd_pend ? mem_rsp_data : rd_data;
        pop            = rd_valid && head_ready_now
                         && ((accept && head_match) || (state_q == ST_WAIT));
        go_wait        = accept && head_match && !head_ready_now;
        restart        = accept && !head_match;
    end

    // Miss-port state: enter wait on a pending head, leave when it is served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (go_wait) begin
            state_q <= ST_WAIT;
        end else if (pop) begin
            state_q <= ST_IDLE;
        end
    end

    // Registered answer to the cache, one cycle after serve or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_addr  <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= pop || restart;
            resp_hit   <= pop;
            resp_addr  <= pop ? rd_addr : miss_addr;
            resp_data  <= pop ? head_data_now : '0;
        end
    end

    // An accepted miss is answered or stalled in the next cycle.
    assert_resp_or_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (resp_valid || !miss_ready));

    // While stalled, no answer is presented.
    assert_stall_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> !resp_valid);

    // Leaving a stall always delivers a hit.
    assert_stall_ends_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_ready) |-> (resp_valid && resp_hit));

endmodule

// File: tb/test_stream_prefetch_buffer.sv
module test_stream_prefetch_buffer;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready, resp_valid, resp_hit;
    logic [AW-1:0] resp_addr, mem_req_addr;
    logic [DW-1:0] resp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [TW-1:0] mem_req_tag;
    logic          mem_rsp_valid;
    logic [TW-1:0] mem_rsp_tag;
    logic [DW-1:0] mem_rsp_data;

    logic          mem_auto = 1'b1;
    logic          man_v = 1'b0;
    logic [TW-1:0] man_tag = '0;
    logic [DW-1:0] man_data = '0;
    logic          a_v = 1'b0;
    logic [TW-1:0] a_tag = '0;
    logic [DW-1:0] a_data = '0;
    logic          cap_v = 1'b0;
    logic [TW-1:0] cap_tag = '0;
    logic [AW-1:0] cap_addr = '0;

    logic [AW-1:0] log_addr [256];
    logic [TW-1:0] log_tag  [256];
    int            req_cnt = 0;
    int            nchk = 0;
    int            nfail = 0;
    int            cyc = 0;

    always #5 clk = ~clk;

    assign mem_rsp_valid = mem_auto ? a_v    : man_v;
    assign mem_rsp_tag   = mem_auto ? a_tag  : man_tag;
    assign mem_rsp_data  = mem_auto ? a_data : man_data;

    stream_prefetch_buffer i_stream_prefetch_buffer (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_addr(resp_addr),
        .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return DW'(a) * 16'd7 + 16'h1357;
    endfunction

    // Memory model: log handshakes, answer one cycle later in auto mode.
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) begin
            log_addr[req_cnt & 255] <= mem_req_addr;
            log_tag[req_cnt & 255]  <= mem_req_tag;
            req_cnt  <= req_cnt + 1;
            cap_v    <= 1'b1;
            cap_tag  <= mem_req_tag;
            cap_addr <= mem_req_addr;
        end else begin
            cap_v <= 1'b0;
        end
    end

    always @(negedge clk) begin
        a_v    = cap_v;
        a_tag  = cap_tag;
        a_data = line_of(cap_addr);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; miss_valid = 1'b0; man_v = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present a miss; return at the negedge after it was accepted.
    task automatic send_miss(input logic [AW-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a;
        for (int k = 0; k < 100 && !miss_ready; k++) @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic wait_resp();
        for (int k = 0; k < 100 && !resp_valid; k++) @(negedge clk);
    endtask

    task automatic man_fill(input logic [TW-1:0] t, input logic [DW-1:0] d);
        man_v = 1'b1; man_tag = t; man_data = d;
        @(negedge clk);
        man_v = 1'b0;
    endtask

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          hit;
    } vec_t;

    // Miss sequence with auto memory; covers R2, R4, R5, R6.
    localparam vec_t VECS [10] = '{
        '{12'h100, 1'b0}, '{12'h101, 1'b1}, '{12'h102, 1'b1},
        '{12'h104, 1'b0}, '{12'h105, 1'b1}, '{12'h105, 1'b0},
        '{12'h106, 1'b1}, '{12'h200, 1'b0}, '{12'h201, 1'b1},
        '{12'h202, 1'b1}
    };

    initial begin
        int base;
        logic [TW-1:0] old_tag;

        // R1: reset state and no fetch before the first miss.
        do_reset();
        check("R1 miss_ready", miss_ready, 1);
        check("R1 resp_valid", resp_valid, 0);
        check("R1 mem_req_valid", mem_req_valid, 0);
        idle(5);
        check("R1 no fetch before miss", req_cnt, 0);

        // Vector table walk.
        foreach (VECS[v]) begin
            send_miss(VECS[v].addr);
            wait_resp();
            check("R2/R6 resp_valid", resp_valid, 1);
            check("R2/R4/R6 resp_hit", resp_hit, VECS[v].hit);
            check("R2/R4 resp_addr", resp_addr, VECS[v].addr);
            if (VECS[v].hit) check("R4 resp_data", resp_data, line_of(VECS[v].addr));
            idle(12);
        end

        // R2 R3 R11: manual memory, no fills; order, depth and slot tags.
        do_reset();
        mem_auto = 1'b0; mem_req_ready = 1'b1;
        base = req_cnt;
        send_miss(12'h050);
        check("R2 miss answered no-hit", {resp_valid, resp_hit}, 2'b10);
        idle(20);
        check("R3 request count", req_cnt - base, 8);
        check("R3 request valid low when full", mem_req_valid, 0);
        for (int i = 0; i < 8; i++) begin
            check("R2 ascending request", log_addr[(base + i) & 255], 12'h051 + i);
            check("R11 slot index", log_tag[(base + i) & 255][2:0], i);
        end
        old_tag = log_tag[base & 255];

        // R7: pending head stalls until its fill.
        send_miss(12'h051);
        check("R7 stalled ready", miss_ready, 0);
        check("R7 no resp while stalled", resp_valid, 0);
        idle(3);
        check("R7 still stalled", miss_ready, 0);
        man_fill(old_tag, 16'hBEEF);
        check("R7 resp after fill", {resp_valid, resp_hit}, 2'b11);
        check("R7 fill data", resp_data, 16'hBEEF);
        idle(2);
        check("R5 refill address", log_addr[(base + 8) & 255], 12'h059);
        check("R5 R11 refill slot", log_tag[(base + 8) & 255][2:0], 0);

        // R8: stale fill after a flush is discarded.
        base = req_cnt;
        send_miss(12'h300);
        check("R6 flush no-hit", {resp_valid, resp_hit}, 2'b10);
        idle(12);
        check("R8 new stream start", log_addr[base & 255], 12'h301);
        man_fill(old_tag, 16'hDEAD);
        idle(1);
        send_miss(12'h301);
        check("R8 stale fill ignored, stall", miss_ready, 0);
        check("R8 no stale resp", resp_valid, 0);
        man_fill(log_tag[base & 255], 16'h1234);
        check("R8 live fill hit", {resp_valid, resp_hit}, 2'b11);
        check("R8 live fill data", resp_data, 16'h1234);

        // R9: address wrap.
        do_reset();
        mem_auto = 1'b1; mem_req_ready = 1'b1;
        base = req_cnt;
        send_miss(12'hFFF);
        idle(12);
        check("R9 wrap first", log_addr[base & 255], 12'h000);
        check("R9 wrap second", log_addr[(base + 1) & 255], 12'h001);
        send_miss(12'h000);
        wait_resp();
        check("R9 hit after wrap", {resp_hit, resp_data}, {1'b1, line_of(12'h000)});

        // R10: request held under back-pressure.
        idle(12);
        mem_req_ready = 1'b0;
        base = req_cnt;
        send_miss(12'h700);
        check("R10 req valid", mem_req_valid, 1);
        check("R10 req addr", mem_req_addr, 12'h701);
        idle(3);
        check("R10 req addr held", mem_req_addr, 12'h701);
        check("R10 no handshake", req_cnt - base, 0);
        mem_req_ready = 1'b1;
        idle(2);
        check("R10 released addr", log_addr[base & 255], 12'h701);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule